// File: doc/BRIEF.md
# Transmit Checksum Offload Inserter

This block sits on the transmit path of an Ethernet MAC and fills in a 16-bit ones-complement checksum for upper-layer protocols. A short sideband control message of five 32-bit words comes before every frame. It says whether to insert a checksum, where the summed region starts, where the result goes, and which 16-bit seed to add. The seed usually carries a pseudo-header partial sum worked out upstream. The block needs no knowledge of any protocol header layout, because every position comes from the control message.

Frame bytes arrive on a byte stream and are written into a local frame store while a running sum is kept. Summing starts at the start offset. Each byte at an even distance from the start offset counts as the high half of a big-endian word, and each byte at an odd distance counts as the low half. When the last byte is in, the sum and the seed are folded to 16 bits and complemented, and the two result bytes are written over the store at the insert offset. The frame is then played out on the output stream. Frames can also be discarded for three reasons: transmit is disabled, the size rule rejects the frame, or the frame does not fit in the store. Frames that are sent add their length to a 64-bit byte counter and raise a one-cycle done pulse.

The control is a six-state machine:
- `ST_HDR` collects the control words. It moves to `ST_LOAD` on a well-formed message.
- `ST_LOAD` takes frame bytes. It moves to `ST_FOLD` on the last byte.
- `ST_FOLD` registers the folded checksum and decides the frame's fate. It goes back to `ST_HDR` on discard, to `ST_PATCH_HI` when insertion is on, and otherwise to `ST_SEND`.
- `ST_PATCH_HI` writes the high checksum byte and always moves to `ST_PATCH_LO`.
- `ST_PATCH_LO` writes the low checksum byte and moves to `ST_SEND`.
- `ST_SEND` streams the frame out. It returns to `ST_HDR` after the final byte.

Top module: `txcsum_inserter`

## Requirements
- R1: A control message is five words, with `ctl_last` on the fifth. Word 0 bit 0 enables insertion. Word 1 bits 31:16 give the start offset and bits 15:0 the insert offset. Word 2 bits 15:0 give the seed, and all other bits are ignored. `in_ready` stays low until a well-formed message has been taken.
- R2: If `ctl_last` arrives on any word other than the fifth, `hdr_err` pulses for one cycle, starting in the cycle after that word. The message is thrown away, and the block waits for a new message with `in_ready` low.
- R3: With insertion enabled, the checksum is computed as follows. Take big-endian 16-bit words from the start offset to the end of the frame, padding an odd final byte with a zero low byte. Add the seed, fold the carries back in until 16 bits remain, and complement. The high byte then replaces frame byte insert offset, and the low byte replaces byte insert offset + 1. The sum uses the bytes as received.
- R4: With insertion disabled, the frame leaves byte for byte as received.
- R5: A checksum byte whose position is at or past the frame end is not written. A start offset at or past the frame end gives the complement of the folded seed alone.
- R6: While `cfg_tx_en` is low when the last byte is taken, the frame is discarded. Nothing appears on the output, the counter does not change, and there is no done pulse.
- R7: With `cfg_jumbo` and `cfg_vlan` both low, frames of 1519 to 1522 bytes are discarded. Frames of 1518 and 1523 bytes pass, and either bit set lets the 1519 to 1522 range pass.
- R8: Output bytes appear only after the whole frame is in and patched. `out_valid`, `out_data` and `out_last` hold while `out_ready` is low, and `out_last` marks exactly the final byte.
- R9: `tx_done` pulses for one cycle in the cycle after the final output byte is accepted. In that same cycle `tx_byte_count` increases by the frame length.
- R10: Frames longer than `BUF_BYTES` (2048) are discarded. A frame of exactly `BUF_BYTES` is sent.
- R11: After reset, `ctl_ready` is high, `in_ready`, `out_valid`, `tx_done` and `hdr_err` are low, and `tx_byte_count` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_tx_en | input | 1 | Transmit enable; frames are discarded while low |
| cfg_jumbo | input | 1 | Allow oversize frames |
| cfg_vlan | input | 1 | Allow tagged-size frames (1519 to 1522) |
| ctl_valid | input | 1 | Control word valid |
| ctl_ready | output | 1 | Control word accepted |
| ctl_data | input | 32 | Control word |
| ctl_last | input | 1 | Final control word of a message |
| in_valid | input | 1 | Frame byte valid |
| in_ready | output | 1 | Frame byte accepted |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Final byte of the frame |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final output byte |
| tx_done | output | 1 | One-cycle pulse per transmitted frame |
| tx_byte_count | output | 64 | Total bytes transmitted |
| hdr_err | output | 1 | One-cycle pulse on a malformed control message |

## Verification
The state machine and the frame store can each fail in ways that show up at the ports.

- A state machine stuck in the wrong state shows at once. Either `ctl_ready` and `in_ready` both stay low, or output begins while bytes are still being accepted, and a bound property catches that second case in the same cycle.
- A wrong fill or patch of the frame store shows only when that frame plays out, a few cycles after its last byte. The bench therefore compares each transmitted frame byte for byte against a reference frame patched by an independent checksum model.
- A bad length or drop decision shows within one frame. The frame either goes missing or appears unexpectedly, and the done pulse or byte counter moves when it should not, or fails to move when it should.

// File: rtl/txcsum_pkg.sv
package txcsum_pkg;

    // Controller states
    typedef enum logic [2:0] {
        ST_HDR,
        ST_LOAD,
        ST_FOLD,
        ST_PATCH_HI,
        ST_PATCH_LO,
        ST_SEND
    } st_e;

    // Control message shape
    localparam int HDR_WORDS   = 5;
    localparam int EN_BIT      = 0;   // word 0
    localparam int START_LSB   = 16;  // word 1 upper half
    localparam int INSERT_LSB  = 0;   // word 1 lower half
    localparam int SEED_LSB    = 0;   // word 2 lower half

endpackage

// File: rtl/txcsum_hdr.sv
module txcsum_hdr
    import txcsum_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        take,
    input  logic        ctl_valid,
    input  logic [31:0] ctl_data,
    input  logic        ctl_last,
    output logic        hdr_ok,
    output logic        hdr_bad,
    output logic        csum_en,
    output logic [15:0] start_off,
    output logic [15:0] ins_off,
    output logic [15:0] seed
);
    localparam int IDX_W = $clog2(HDR_WORDS + 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(HDR_WORDS - 1);
    localparam logic [IDX_W-1:0] IDX_SAT  = IDX_W'(HDR_WORDS);

    logic [IDX_W-1:0] idx_q;
    logic             fire;
    logic             unused_bits;

    assign fire        = take && ctl_valid;
    assign hdr_ok      = fire && ctl_last && (idx_q == IDX_LAST);
    assign hdr_bad     = fire && ctl_last && (idx_q != IDX_LAST);
    assign unused_bits = ^{ctl_data[31:16], ctl_data[15:1]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q     <= '0;
            csum_en   <= 1'b0;
            start_off <= '0;
            ins_off   <= '0;
            seed      <= '0;
        end else if (fire) begin
            if (ctl_last)
                idx_q <= '0;
            else if (idx_q != IDX_SAT)
                idx_q <= idx_q + 1'b1;
            case (idx_q)
                IDX_W'(0): csum_en <= ctl_data[EN_BIT];
                IDX_W'(1): begin
                    start_off <= ctl_data[START_LSB +: 16];
                    ins_off   <= ctl_data[INSERT_LSB +: 16];
                end
                IDX_W'(2): seed <= ctl_data[SEED_LSB +: 16];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/txcsum_acc.sv
module txcsum_acc #(
    parameter int SUM_W = 32,
    parameter int LEN_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             byte_vld,
    input  logic [7:0]       byte_data,
    input  logic [LEN_W-1:0] byte_idx,
    input  logic [15:0]      start_off,
    input  logic [15:0]      seed,
    input  logic             fold_en,
    output logic [15:0]      csum
);
    localparam int CMP_W = (LEN_W > 16) ? LEN_W + 1 : 17;
    localparam int FOLDS = SUM_W / 16 + 1;

    logic [SUM_W-1:0] sum_q;
    logic [SUM_W-1:0] folded;
    logic [15:0]      term;
    logic             in_range;
    logic             high_half;

    assign in_range  = CMP_W'(byte_idx) >= CMP_W'(start_off);
    assign high_half = ~(byte_idx[0] ^ start_off[0]);
    assign term      = high_half ? {byte_data, 8'h00} : {8'h00, byte_data};

    always_comb begin
        folded = sum_q + SUM_W'(seed);
        for (int k = 0; k < FOLDS; k++)
            folded = SUM_W'(folded[15:0]) + (folded >> 16);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
            csum  <= '0;
        end else begin
            if (clr)
                sum_q <= '0;
            else if (byte_vld && in_range)
                sum_q <= sum_q + SUM_W'(term);
            if (fold_en)
                csum <= ~folded[15:0];
        end
    end
endmodule

// File: rtl/txcsum_buf.sv
module txcsum_buf #(
    parameter int DEPTH = 2048,
    parameter int PTR_W = 11
) (
    input  logic             clk,
    input  logic             we,
    input  logic [PTR_W-1:0] waddr,
    input  logic [7:0]       wdata,
    input  logic [PTR_W-1:0] raddr,
    output logic [7:0]       rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/txcsum_inserter.sv
module txcsum_inserter
    import txcsum_pkg::*;
#(
    parameter int BUF_BYTES = 2048,
    parameter int SUM_W     = 32,
    parameter int CNT_W     = 64,
    parameter int STD_MAX   = 1518,
    parameter int TAG_BYTES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_tx_en,
    input  logic             cfg_jumbo,
    input  logic             cfg_vlan,
    input  logic             ctl_valid,
    output logic             ctl_ready,
    input  logic [31:0]      ctl_data,
    input  logic             ctl_last,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_data,
    output logic             out_last,
    output logic             tx_done,
    output logic [CNT_W-1:0] tx_byte_count,
    output logic             hdr_err
);
    localparam int PTR_W = $clog2(BUF_BYTES);
    localparam int LEN_W = PTR_W + 2;
    localparam int CMP_W = (LEN_W > 16) ? LEN_W + 1 : 17;
    localparam logic [LEN_W-1:0] LEN_BUF  = LEN_W'(BUF_BYTES);
    localparam logic [LEN_W-1:0] LEN_STD  = LEN_W'(STD_MAX);
    localparam logic [LEN_W-1:0] LEN_TAG  = LEN_W'(STD_MAX + TAG_BYTES);

    st_e state, state_n;

    logic             hdr_ok, hdr_bad, csum_en;
    logic [15:0]      start_off, ins_off, seed, csum;
    logic [LEN_W-1:0] len_q;
    logic [PTR_W-1:0] rd_ptr;
    logic             in_fire, out_fire, drop_c;
    logic [CMP_W-1:0] len_ext, ins_ext, ins_nxt;
    logic             buf_we;
    logic [PTR_W-1:0] buf_waddr;
    logic [7:0]       buf_wdata;

    assign in_fire  = in_valid && in_ready;
    assign out_fire = out_valid && out_ready;
    assign len_ext  = CMP_W'(len_q);
    assign ins_ext  = CMP_W'(ins_off);
    assign ins_nxt  = ins_ext + CMP_W'(1);

    // Discard decision, evaluated once the frame length is final
    assign drop_c = !cfg_tx_en
                 || (len_q > LEN_BUF)
                 || (!cfg_jumbo && !cfg_vlan && (len_q > LEN_STD) && (len_q <= LEN_TAG));

    txcsum_hdr u_hdr (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (ctl_ready),
        .ctl_valid (ctl_valid),
        .ctl_data  (ctl_data),
        .ctl_last  (ctl_last),
        .hdr_ok    (hdr_ok),
        .hdr_bad   (hdr_bad),
        .csum_en   (csum_en),
        .start_off (start_off),
        .ins_off   (ins_off),
        .seed      (seed)
    );

    txcsum_acc #(.SUM_W(SUM_W), .LEN_W(LEN_W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (state == ST_HDR),
        .byte_vld  (in_fire),
        .byte_data (in_data),
        .byte_idx  (len_q),
        .start_off (start_off),
        .seed      (seed),
        .fold_en   (state == ST_FOLD),
        .csum      (csum)
    );

    txcsum_buf #(.DEPTH(BUF_BYTES), .PTR_W(PTR_W)) u_buf (
        .clk   (clk),
        .we    (buf_we),
        .waddr (buf_waddr),
        .wdata (buf_wdata),
        .raddr (rd_ptr),
        .rdata (out_data)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_HDR;
        else
            state <= state_n;
    end

    // Transitions
    always_comb begin
        state_n = state;
        unique case (state)
            ST_HDR:      if (hdr_ok) state_n = ST_LOAD;
            ST_LOAD:     if (in_fire && in_last) state_n = ST_FOLD;
            ST_FOLD:     state_n = drop_c ? ST_HDR : (csum_en ? ST_PATCH_HI : ST_SEND);
            ST_PATCH_HI: state_n = ST_PATCH_LO;
            ST_PATCH_LO: state_n = ST_SEND;
            ST_SEND:     if (out_fire && out_last) state_n = ST_HDR;
            default:     state_n = ST_HDR;
        endcase
    end

    // Outputs and store write port
    always_comb begin
        ctl_ready = (state == ST_HDR);
        in_ready  = (state == ST_LOAD);
        out_valid = (state == ST_SEND);
        out_last  = (LEN_W'(rd_ptr) + LEN_W'(1)) == len_q;
        buf_we    = 1'b0;
        buf_waddr = len_q[PTR_W-1:0];
        buf_wdata = in_data;
        case (state)
            ST_LOAD: buf_we = in_fire && (len_q < LEN_BUF);
            ST_PATCH_HI: begin
                buf_we    = ins_ext < len_ext;
                buf_waddr = ins_ext[PTR_W-1:0];
                buf_wdata = csum[15:8];
            end
            ST_PATCH_LO: begin
                buf_we    = ins_nxt < len_ext;
                buf_waddr = ins_nxt[PTR_W-1:0];
                buf_wdata = csum[7:0];
            end
            default: ;
        endcase
    end

    // Frame length, read pointer, counter and pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q         <= '0;
            rd_ptr        <= '0;
            tx_done       <= 1'b0;
            tx_byte_count <= '0;
            hdr_err       <= 1'b0;
        end else begin
            hdr_err <= hdr_bad;
            tx_done <= out_fire && out_last;
            if (state == ST_HDR)
                len_q <= '0;
            else if (in_fire && (len_q != '1))
                len_q <= len_q + 1'b1;
            if (state == ST_FOLD)
                rd_ptr <= '0;
            else if (out_fire)
                rd_ptr <= rd_ptr + 1'b1;
            if (out_fire && out_last)
                tx_byte_count <= tx_byte_count + CNT_W'(len_q);
        end
    end
endmodule

// File: rtl/txcsum_chk.sv
module txcsum_chk #(
    parameter int CNT_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_valid,
    input logic             ctl_ready,
    input logic             ctl_last,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [7:0]       out_data,
    input logic             out_last,
    input logic             tx_done,
    input logic [CNT_W-1:0] tx_byte_count,
    input logic             hdr_err
);
    // R1: no frame byte is taken while a control message is pending
    a_r1_hdr_before_data: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_ready |-> !in_ready);

    // R2: error pulse only after a closing control word
    a_r2_err_source: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_err |-> $past(ctl_valid && ctl_ready && ctl_last));

    // R8: output waits for the whole frame
    a_r8_no_early_out: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !out_valid);

    // R8: output holds under backpressure
    a_r8_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

    // R9: done pulse follows the final accepted byte
    a_r9_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> $past(out_valid && out_ready && out_last));

    // R9: counter moves only with a done pulse
    a_r9_count_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_byte_count != $past(tx_byte_count)) |-> tx_done);
endmodule

bind txcsum_inserter txcsum_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctl_valid     (ctl_valid),
    .ctl_ready     (ctl_ready),
    .ctl_last      (ctl_last),
    .in_ready      (in_ready),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_data      (out_data),
    .out_last      (out_last),
    .tx_done       (tx_done),
    .tx_byte_count (tx_byte_count),
    .hdr_err       (hdr_err)
);

// File: tb/tb_txcsum_inserter.sv
`timescale 1ns/1ps
module tb_txcsum_inserter;

    typedef struct packed {
        logic [11:0] len;
        logic [15:0] st;
        logic [15:0] ins;
        logic [15:0] seed;
        logic        en;
        logic        txe;
        logic        jum;
        logic        vln;
        logic        bp;
        logic        pass;
    } vec_t;

    localparam int NV = 15;
    // len, start, insert, seed, en, txe, jumbo, vlan, backpressure, expect sent
    localparam vec_t VECS [NV] = '{
        '{12'd60,   16'd14, 16'd50,   16'h1234, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R3
        '{12'd61,   16'd15, 16'd16,   16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1}, // R3 odd tail, R8
        '{12'd40,   16'd0,  16'd4,    16'hffff, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R4
        '{12'd1520, 16'd0,  16'd10,   16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R7
        '{12'd1520, 16'd0,  16'd10,   16'h0abc, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1}, // R7 vlan
        '{12'd1521, 16'd3,  16'd7,    16'h1111, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}, // R7 jumbo
        '{12'd50,   16'd0,  16'd2,    16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R6
        '{12'd1519, 16'd0,  16'd0,    16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R7
        '{12'd1522, 16'd0,  16'd0,    16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R7
        '{12'd1518, 16'd14, 16'd24,   16'h8000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R7 edge
        '{12'd1523, 16'd14, 16'd24,   16'h8001, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R7 edge
        '{12'd30,   16'd2,  16'd29,   16'h4321, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R5 half patch
        '{12'd20,   16'd40, 16'd0,    16'h5555, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R5 start past end
        '{12'd2100, 16'd0,  16'd0,    16'h0000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R10
        '{12'd2048, 16'd0,  16'd2046, 16'hffff, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1}  // R10 full store
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_tx_en = 1'b1, cfg_jumbo = 1'b0, cfg_vlan = 1'b0;
    logic        ctl_valid = 1'b0, ctl_last = 1'b0;
    logic [31:0] ctl_data = '0;
    logic        in_valid = 1'b0, in_last = 1'b0;
    logic [7:0]  in_data = '0;
    logic        out_ready = 1'b0;
    logic        ctl_ready, in_ready, out_valid, out_last, tx_done, hdr_err;
    logic [7:0]  out_data;
    logic [63:0] tx_byte_count;

    always #2.5 clk = ~clk;

    txcsum_inserter dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_tx_en(cfg_tx_en), .cfg_jumbo(cfg_jumbo), .cfg_vlan(cfg_vlan),
        .ctl_valid(ctl_valid), .ctl_ready(ctl_ready), .ctl_data(ctl_data), .ctl_last(ctl_last),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
        .tx_done(tx_done), .tx_byte_count(tx_byte_count), .hdr_err(hdr_err)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [63:0] exp_cnt = '0;
    logic [7:0] fr  [4096];
    logic [7:0] ef  [4096];
    logic [7:0] got [4096];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_csum(input int len, input int st, input logic [15:0] sd);
        longint s = longint'(sd);
        for (int i = st; i < len; i += 2)
            s += longint'({fr[i], (i + 1 < len) ? fr[i+1] : 8'h00});
        while ((s >> 16) != 0)
            s = (s & 64'hffff) + (s >> 16);
        return ~s[15:0];
    endfunction

    task automatic send_ctl(input logic [31:0] d, input bit last);
        @(negedge clk);
        ctl_valid = 1'b1; ctl_data = d; ctl_last = last;
        while (!ctl_ready) @(negedge clk);
    endtask

    task automatic ctl_idle();
        @(negedge clk);
        ctl_valid = 1'b0; ctl_last = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d, input bit last);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_last = last;
        while (!in_ready) @(negedge clk);
    endtask

    task automatic run_vec(input vec_t v, input int vi);
        int len = int'(v.len);
        logic [15:0] cs;
        int n = 0;
        int k = 0;
        int mism = 0;
        int first_bad = -1;
        bit got_last = 1'b0;
        bit seen = 1'b0;
        string tag;
        for (int i = 0; i < len; i++) fr[i] = 8'(i * 37 + vi * 11 + 5);
        for (int i = 0; i < len; i++) ef[i] = fr[i];
        if (v.en) begin
            cs = ref_csum(len, int'(v.st), v.seed);
            if (int'(v.ins) < len)     ef[v.ins]     = cs[15:8];
            if (int'(v.ins) + 1 < len) ef[v.ins + 1] = cs[7:0];
        end
        if (!v.txe)           tag = "R6";
        else if (len > 2048)  tag = "R10";
        else if (!v.pass)     tag = "R7";
        else if (!v.en)       tag = "R4";
        else                  tag = "R3/R5/R7";
        @(negedge clk);
        cfg_tx_en = v.txe; cfg_jumbo = v.jum; cfg_vlan = v.vln;
        send_ctl(32'h0000_0000 | {31'h3fff_fff0, v.en}, 1'b0);       // R1 junk upper bits
        send_ctl({v.st, v.ins}, 1'b0);
        send_ctl({16'hdead, v.seed}, 1'b0);
        send_ctl(32'h0, 1'b0);
        send_ctl(32'hffff_ffff, 1'b1);
        ctl_idle();
        for (int i = 0; i < len; i++) send_byte(fr[i], i == len - 1);
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        if (v.pass) begin
            while (!got_last && n <= len + 2) begin
                out_ready = v.bp ? (k % 3 != 0) : 1'b1;
                k++;
                if (out_valid && out_ready) begin
                    got[n] = out_data;
                    if (out_last) got_last = 1'b1;
                    n++;
                end
                @(negedge clk);
            end
            out_ready = 1'b0;
            exp_cnt += 64'(len);
            check(tx_done == 1'b1, "R9", $sformatf("vec %0d done pulse", vi), longint'(tx_done), 1);
            check(tx_byte_count == exp_cnt, "R9", $sformatf("vec %0d byte count", vi),
                  longint'(tx_byte_count), longint'(exp_cnt));
            check(n == len, "R8", $sformatf("vec %0d length at out_last", vi), n, len);
            for (int i = 0; i < len && i < n; i++)
                if (got[i] !== ef[i]) begin
                    mism++;
                    if (first_bad < 0) first_bad = i;
                end
            check(mism == 0, tag, $sformatf("vec %0d data, first bad byte %0d", vi, first_bad),
                  (first_bad >= 0) ? longint'(got[first_bad]) : 0,
                  (first_bad >= 0) ? longint'(ef[first_bad]) : 0);
            @(negedge clk);
            check(tx_done == 1'b0, "R9", $sformatf("vec %0d pulse width", vi), longint'(tx_done), 0);
        end else begin
            out_ready = 1'b1;
            for (int i = 0; i < 8; i++) begin
                if (out_valid || tx_done) seen = 1'b1;
                @(negedge clk);
            end
            out_ready = 1'b0;
            check(!seen, tag, $sformatf("vec %0d discarded, no output", vi), longint'(seen), 0);
            check(tx_byte_count == exp_cnt && ctl_ready, tag, $sformatf("vec %0d count unchanged", vi),
                  longint'(tx_byte_count), longint'(exp_cnt));
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R11 watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(ctl_ready && !in_ready && !out_valid, "R11", "handshake state after reset",
              longint'({ctl_ready, in_ready, out_valid}), 64'h4);
        check(tx_byte_count == 0 && !tx_done && !hdr_err, "R11", "counter and pulses after reset",
              longint'(tx_byte_count), 0);
        // R1 no byte accepted without a control message
        in_valid = 1'b1; in_data = 8'h55;
        repeat (3) @(negedge clk);
        check(!in_ready && !out_valid, "R1", "frame bytes held before control message",
              longint'(in_ready), 0);
        in_valid = 1'b0;

        for (int vi = 0; vi < NV; vi++) run_vec(VECS[vi], vi);

        // R2 short message: four words
        send_ctl(32'h1, 1'b0);
        send_ctl(32'h0, 1'b0);
        send_ctl(32'h0, 1'b0);
        send_ctl(32'h0, 1'b1);
        ctl_idle();
        check(hdr_err == 1'b1, "R2", "short message error pulse", longint'(hdr_err), 1);
        @(negedge clk);
        check(!hdr_err && ctl_ready && !in_ready, "R2", "short message discarded",
              longint'({hdr_err, ctl_ready, in_ready}), 64'h2);
        // R2 long message: six words
        for (int i = 0; i < 6; i++) send_ctl(32'h1, i == 5);
        ctl_idle();
        check(hdr_err == 1'b1, "R2", "long message error pulse", longint'(hdr_err), 1);
        @(negedge clk);
        check(!in_ready, "R2", "long message leaves frame input closed", longint'(in_ready), 0);
        // R2 recovery with a well-formed message
        run_vec(VECS[0], 0);

        finish_run();
    end
endmodule